// File: doc/BRIEF.md
# CPU Hotplug Selector Register File

This block is the register window through which platform firmware and the operating system manage CPU hot-add and hot-remove. Each possible CPU owns a small set of flags: enabled, insert event pending, remove event pending, and eject handed to firmware. Software first picks one CPU by writing a selector. Every other register then reads or writes the flags and identity of that CPU only. If the selector holds a value outside the CPU range, the rest of the window goes dark: reads give zero and writes are dropped.

A command byte sets what the data registers mean. The commands are: find a CPU with a pending event, write the OST event value, write the OST status value, or read the architectural CPU ID. The find command is a single-cycle priority search from CPU 0 upward, and it moves the selector in hardware. The platform side drives per-CPU hot-add and hot-remove pulses and per-CPU 64-bit ID constants. The block in turn emits an eject pulse with a CPU index, an OST-update pulse with both OST values, and a general-purpose event pulse.

The bus side works in 32-bit words with byte strobes. Word 0 is byte offset 0x0, word 1 is 0x4, word 2 is 0x8 and word 3 is 0xC. A read returns its data with `rvalid` one cycle after `rd_en`. The last stored command is held in a state machine:
- `CMD_SEL` is the state after reset, and is entered on command 0.
- `CMD_OST_EV` is entered on command 1.
- `CMD_OST_ST` is entered on command 2.
- `CMD_CPUID` is entered on command 3.
- `CMD_NONE` is entered on any other command value.

Only an accepted command write moves the machine. All other cycles hold the state.

Top module: `cpu_hotplug_regs`

## Requirements
- R1: A write to word 0 with all four strobes set stores the full 32-bit value as the selector, whatever the value. A selector below NCPU is valid. The selector is 0 at power-up, and reset leaves it unchanged.
- R2: While the selector is invalid, every read returns 0. Writes to words 1 and 2 are dropped, so neither the flags nor the command change.
- R3: A read of word 1 returns the status of the selected CPU in byte 0. Bit 0 is enabled, bit 1 is insert pending, bit 2 is remove pending and bit 4 is eject handed to firmware. Bit 3 and bits 5 to 7 read 0.
- R4: A hot_add pulse sets the enabled and insert flags of its CPU. A hot_remove pulse sets the remove flag of an enabled CPU. Either one, when it has an effect, raises gpe_pulse in the next cycle. A hot_remove for a CPU that is not enabled raises nothing.
- R5: A write to word 1 with strobe 0 acts on the selected CPU:
  - data bit 1 clears the insert flag;
  - data bit 2 clears the remove flag;
  - data bit 3 ejects the CPU. This clears its enabled, remove and firmware-eject flags. In the next cycle it raises eject_pulse with eject_cpu set to the selector, and raises gpe_pulse.
- R6: Control data bit 4, written without bit 3, sets the firmware-eject flag. Control data bits 0 and 5 to 7 have no effect.
- R7: A write of command 0 (word 1, strobe 1, data bits 15:8) moves the selector to the lowest-numbered CPU with an insert or remove flag set. If no CPU has one, the selector and all flags stay unchanged.
- R8: A read of word 2 returns the selector under command 0. Under command 3 it returns bits 31:0 of the selected CPU's ID. Under any other command it returns 0.
- R9: A read of word 0 returns bits 63:32 of the selected CPU's ID under command 3, and 0 under any other command.
- R10: A write to word 2 with all strobes set stores the OST event register under command 1. Under command 2 it stores the OST status register, and in the next cycle raises ost_pulse with both values on ost_event and ost_status. Under command 1 it raises no ost_pulse.
- R11: The reserved areas read 0: bytes 1 to 3 of word 1, and all of word 3. Writes to them are ignored, as is any write to word 0 or word 2 without all four strobes set.
- R12: rvalid is 0 in reset. A read raises rvalid with its data exactly one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (selector excepted) |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| word_addr | input | 2 | Word index: 0=0x0, 1=0x4, 2=0x8, 3=0xC |
| wstrb | input | 4 | Byte strobes for the write, bit n = byte n |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| hot_add | input | NCPU | Per-CPU hot-add pulses |
| hot_remove | input | NCPU | Per-CPU hot-remove request pulses |
| cpu_id | input | 64*NCPU | Per-CPU architectural ID, CPU i at bits 64*i+63:64*i |
| eject_pulse | output | 1 | One-cycle pulse when a CPU is ejected |
| eject_cpu | output | SEL_W | Index of the ejected CPU, valid with eject_pulse |
| gpe_pulse | output | 1 | One-cycle hotplug event notification |
| ost_pulse | output | 1 | One-cycle OST update notification |
| ost_event | output | 32 | Stored OST event value |
| ost_status | output | 32 | Stored OST status value |

## Verification
Some properties are checked on every cycle:
- a read under an invalid selector comes back as zero;
- the command state holds while the selector is invalid;
- a failed search leaves the selector stable, and a successful one lands on a pending CPU;
- an eject clears the flags of its CPU, and a hot-add sets them;
- a read always answers one cycle after it is issued;
- an OST pulse occurs only in the status-write command state.

The scenarios show the rest: lowest-index priority when several CPUs are pending at once, the exact status-byte encoding, and ID-word selection by command. They also cover the drops under a bad selector that can only be seen through later reads, reserved-byte and partial-strobe writes, and the selector keeping its value across a reset.

// File: rtl/chp_pkg.sv
package chp_pkg;

    typedef enum logic [2:0] {
        CMD_SEL    = 3'd0,
        CMD_OST_EV = 3'd1,
        CMD_OST_ST = 3'd2,
        CMD_CPUID  = 3'd3,
        CMD_NONE   = 3'd4
    } cmd_state_e;

    localparam logic [1:0] W_SEL  = 2'd0;
    localparam logic [1:0] W_CTL  = 2'd1;
    localparam logic [1:0] W_DATA = 2'd2;

    localparam int CTL_CLR_INS = 1;
    localparam int CTL_CLR_REM = 2;
    localparam int CTL_EJECT   = 3;
    localparam int CTL_FW_EJ   = 4;

endpackage

// File: rtl/chp_cmd_fsm.sv
module chp_cmd_fsm
    import chp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic [7:0] cmd_val_i,
    output cmd_state_e state_o,
    output logic       rd_hi_id_o,
    output logic       rd_lo_sel_o,
    output logic       rd_lo_id_o,
    output logic       wr_ost_ev_o,
    output logic       wr_ost_st_o
);

    cmd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_wr_i) begin
            unique case (cmd_val_i)
                8'd0:    state_d = CMD_SEL;
                8'd1:    state_d = CMD_OST_EV;
                8'd2:    state_d = CMD_OST_ST;
                8'd3:    state_d = CMD_CPUID;
                default: state_d = CMD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_SEL;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_hi_id_o  = 1'b0;
        rd_lo_sel_o = 1'b0;
        rd_lo_id_o  = 1'b0;
        wr_ost_ev_o = 1'b0;
        wr_ost_st_o = 1'b0;
        unique case (state_q)
            CMD_SEL:    rd_lo_sel_o = 1'b1;
            CMD_OST_EV: wr_ost_ev_o = 1'b1;
            CMD_OST_ST: wr_ost_st_o = 1'b1;
            CMD_CPUID: begin
                rd_hi_id_o = 1'b1;
                rd_lo_id_o = 1'b1;
            end
            CMD_NONE: ;
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R8: a command-0 write lands the machine in the selector state
    assert_cmd0_enters_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_val_i == 8'd0) |=> state_q == CMD_SEL);

    // R8: without a command write the state holds
    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr_i |=> $stable(state_q));

endmodule

// File: rtl/chp_cpu_slot.sv
module chp_cpu_slot #(
    parameter logic BOOT_EN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic remove_i,
    input  logic sel_i,
    input  logic clr_ins_i,
    input  logic clr_rem_i,
    input  logic eject_i,
    input  logic fw_req_i,
    output logic en_o,
    output logic ins_o,
    output logic rem_o,
    output logic ejr_o
);

    logic en_q, ins_q, rem_q, ejr_q;
    logic eject_go;

    assign eject_go = sel_i & eject_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= BOOT_EN;
            ins_q <= 1'b0;
            rem_q <= 1'b0;
            ejr_q <= 1'b0;
        end else begin
            en_q  <= add_i | (en_q & ~eject_go);
            ins_q <= add_i | (ins_q & ~(sel_i & clr_ins_i));
            rem_q <= (remove_i & en_q) | (rem_q & ~(sel_i & clr_rem_i) & ~eject_go);
            ejr_q <= (ejr_q & ~eject_go) | (sel_i & fw_req_i & ~eject_i);
        end
    end

    assign en_o  = en_q;
    assign ins_o = ins_q;
    assign rem_o = rem_q;
    assign ejr_o = ejr_q;

    // R5: an eject of this CPU leaves it disabled with no firmware request
    assert_eject_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && eject_i && !add_i) |=> (!en_o && !ejr_o));

    // R4: a hot-add marks the CPU enabled with an insert pending
    assert_add_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        add_i |=> (en_o && ins_o));

endmodule

// File: rtl/chp_scan.sv
module chp_scan #(
    parameter int N     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [SEL_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = SEL_W'(i);
            end
        end
    end

    // R7: a hit always names a requesting CPU
    assert_scan_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> req_i[idx_o]);

    // R7: a miss only when nothing is requesting
    assert_scan_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> (req_i == '0));

endmodule

// File: rtl/cpu_hotplug_regs.sv
module cpu_hotplug_regs
    import chp_pkg::*;
#(
    parameter int          NCPU      = 8,
    parameter logic [NCPU-1:0] BOOT_MASK = NCPU'(1),
    localparam int         SEL_W     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [1:0]           word_addr,
    input  logic [3:0]           wstrb,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic                 rvalid,
    input  logic [NCPU-1:0]      hot_add,
    input  logic [NCPU-1:0]      hot_remove,
    input  logic [64*NCPU-1:0]   cpu_id,
    output logic                 eject_pulse,
    output logic [SEL_W-1:0]     eject_cpu,
    output logic                 gpe_pulse,
    output logic                 ost_pulse,
    output logic [31:0]          ost_event,
    output logic [31:0]          ost_status
);

    // Selector: valid at power-up, untouched by reset
    logic [31:0]      sel_q = '0;
    logic             sel_ok;
    logic [SEL_W-1:0] sel_idx;

    assign sel_ok  = sel_q < 32'(NCPU);
    assign sel_idx = sel_q[SEL_W-1:0];

    // Access decode
    logic acc_ok, sel_wr, ctl_wr, cmd_wr, data_wr;

    assign acc_ok  = wr_en & sel_ok;
    assign sel_wr  = wr_en  & (word_addr == W_SEL)  & (wstrb == 4'hF);
    assign ctl_wr  = acc_ok & (word_addr == W_CTL)  & wstrb[0];
    assign cmd_wr  = acc_ok & (word_addr == W_CTL)  & wstrb[1];
    assign data_wr = acc_ok & (word_addr == W_DATA) & (wstrb == 4'hF);

    // Command state machine
    cmd_state_e cmd_state;
    logic rd_hi_id, rd_lo_sel, rd_lo_id, wr_ost_ev, wr_ost_st;

    chp_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr),
        .cmd_val_i   (wdata[15:8]),
        .state_o     (cmd_state),
        .rd_hi_id_o  (rd_hi_id),
        .rd_lo_sel_o (rd_lo_sel),
        .rd_lo_id_o  (rd_lo_id),
        .wr_ost_ev_o (wr_ost_ev),
        .wr_ost_st_o (wr_ost_st)
    );

    // Per-CPU flag slots
    logic [NCPU-1:0] en_v, ins_v, rem_v, ejr_v;
    logic [63:0]     id_arr [NCPU];

    for (genvar i = 0; i < NCPU; i++) begin : g_slot
        logic hit;
        assign hit       = ctl_wr & (sel_idx == SEL_W'(i));
        assign id_arr[i] = cpu_id[64*i +: 64];

        chp_cpu_slot #(.BOOT_EN(BOOT_MASK[i])) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .add_i     (hot_add[i]),
            .remove_i  (hot_remove[i]),
            .sel_i     (hit),
            .clr_ins_i (wdata[CTL_CLR_INS]),
            .clr_rem_i (wdata[CTL_CLR_REM]),
            .eject_i   (wdata[CTL_EJECT]),
            .fw_req_i  (wdata[CTL_FW_EJ]),
            .en_o      (en_v[i]),
            .ins_o     (ins_v[i]),
            .rem_o     (rem_v[i]),
            .ejr_o     (ejr_v[i])
        );
    end

    // Pending-event search
    logic             scan_found;
    logic [SEL_W-1:0] scan_idx;
    logic             scan_go;

    chp_scan #(.N(NCPU), .SEL_W(SEL_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (ins_v | rem_v),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    assign scan_go = cmd_wr & (wdata[15:8] == 8'd0);

    always_ff @(posedge clk) begin
        if (sel_wr)                     sel_q <= wdata;
        else if (scan_go && scan_found) sel_q <= 32'(scan_idx);
    end

    // Read path
    logic [63:0] id_sel;
    logic [7:0]  status;
    logic [31:0] rd_word;

    assign id_sel = sel_ok ? id_arr[sel_idx] : 64'd0;
    assign status = {3'b000, ejr_v[sel_idx], 1'b0, rem_v[sel_idx], ins_v[sel_idx], en_v[sel_idx]};

    always_comb begin
        rd_word = 32'd0;
        if (sel_ok) begin
            unique case (word_addr)
                W_SEL:   rd_word = rd_hi_id ? id_sel[63:32] : 32'd0;
                W_CTL:   rd_word = {24'd0, status};
                W_DATA:  rd_word = rd_lo_sel ? sel_q : (rd_lo_id ? id_sel[31:0] : 32'd0);
                default: rd_word = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= 32'd0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_word;
        end
    end

    // Notification outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eject_pulse <= 1'b0;
            eject_cpu   <= '0;
            gpe_pulse   <= 1'b0;
            ost_pulse   <= 1'b0;
            ost_event   <= 32'd0;
            ost_status  <= 32'd0;
        end else begin
            eject_pulse <= ctl_wr & wdata[CTL_EJECT];
            if (ctl_wr && wdata[CTL_EJECT]) eject_cpu <= sel_idx;
            gpe_pulse   <= (|hot_add) | (|(hot_remove & en_v)) | (ctl_wr & wdata[CTL_EJECT]);
            ost_pulse   <= data_wr & wr_ost_st;
            if (data_wr && wr_ost_ev) ost_event  <= wdata;
            if (data_wr && wr_ost_st) ost_status <= wdata;
        end
    end

    // R2: reads under a bad selector return zero
    assert_bad_sel_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !$past(sel_ok)) |-> rdata == 32'd0);

    // R2: the command cannot move under a bad selector
    assert_bad_sel_holds_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_ok) |=> $stable(cmd_state));

    // R7: a fruitless search leaves the selector alone
    assert_scan_miss_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_go && !scan_found) |=> $stable(sel_q));

    // R12: every read answers one cycle later
    assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    // R10: an OST pulse only follows a status write
    assert_ost_pulse_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ost_pulse |-> cmd_state == CMD_OST_ST);

endmodule

// File: tb/tb_cpu_hotplug_regs.sv
`timescale 1ns/1ps
module tb_cpu_hotplug_regs;

    localparam int NCPU  = 8;
    localparam int SEL_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]        word_addr = '0;
    logic [3:0]        wstrb = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [NCPU-1:0]   hot_add = '0, hot_remove = '0;
    logic [64*NCPU-1:0] cpu_id;
    logic              eject_pulse, gpe_pulse, ost_pulse;
    logic [SEL_W-1:0]  eject_cpu;
    logic [31:0]       ost_event, ost_status;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    function automatic logic [31:0] id_lo(int i); return 32'h0000_0100 + 32'(i); endfunction
    function automatic logic [31:0] id_hi(int i); return 32'hC0DE_0000 + 32'(i); endfunction

    for (genvar g = 0; g < NCPU; g++) begin : g_id
        assign cpu_id[64*g +: 64] = {id_hi(g), id_lo(g)};
    end

    cpu_hotplug_regs #(.NCPU(NCPU)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .word_addr(word_addr), .wstrb(wstrb), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .hot_add(hot_add), .hot_remove(hot_remove),
        .cpu_id(cpu_id), .eject_pulse(eject_pulse), .eject_cpu(eject_cpu),
        .gpe_pulse(gpe_pulse), .ost_pulse(ost_pulse),
        .ost_event(ost_event), .ost_status(ost_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        word_addr = w; wstrb = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wstrb = '0;
    endtask

    task automatic cmd(input logic [7:0] c);
        wr(2'd1, 4'b0010, {16'd0, c, 8'd0});
    endtask

    task automatic rd(input logic [1:0] w, input logic [31:0] e, input string tag);
        @(negedge clk);
        word_addr = w; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic hot(input logic [NCPU-1:0] a, input logic [NCPU-1:0] r,
                       input logic e, input string tag);
        @(negedge clk);
        hot_add = a; hot_remove = r;
        @(negedge clk);
        hot_add = '0; hot_remove = '0;
        chk(tag, 32'(gpe_pulse), 32'(e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Scoreboard monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: actual=rvalid expected=no read outstanding");
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, rdata, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset rvalid", 32'(rvalid), 0);
        chk("R5 reset eject", 32'(eject_pulse), 0);
        chk("R10 reset ost", 32'(ost_pulse), 0);
        rst_n = 1'b1;

        // Boot CPU only, nothing pending
        wr(2'd0, 4'hF, 0);
        cmd(8'd0);
        rd(2'd1, 32'h01, "R3 boot status");
        rd(2'd2, 32'd0,  "R8 selector read");
        rd(2'd0, 32'd0,  "R9 cmd0 word0");

        // Hot-add CPU 5, find it
        hot(8'h20, 8'h00, 1'b1, "R4 gpe on add");
        cmd(8'd0);
        rd(2'd1, 32'h03, "R4 add status");
        rd(2'd2, 32'd5,  "R7 scan to 5");

        // Several pending: lowest first
        hot(8'h48, 8'h00, 1'b1, "R4 gpe on add pair");
        wr(2'd0, 4'hF, 0);
        cmd(8'd0);
        rd(2'd2, 32'd3,  "R7 lowest pending");
        wr(2'd1, 4'b0001, 32'h02);
        rd(2'd1, 32'h01, "R5 clear insert");
        cmd(8'd0);
        rd(2'd2, 32'd5,  "R7 next pending");
        wr(2'd1, 4'b0001, 32'h02);
        cmd(8'd0);
        rd(2'd2, 32'd6,  "R7 last pending");
        wr(2'd1, 4'b0001, 32'h02);
        cmd(8'd0);
        rd(2'd2, 32'd6,  "R7 none pending keeps sel");
        rd(2'd1, 32'h01, "R7 flags unchanged");

        // ID reads
        cmd(8'd3);
        rd(2'd2, id_lo(6), "R8 id low");
        rd(2'd0, id_hi(6), "R9 id high");
        cmd(8'd1);
        rd(2'd2, 32'd0, "R8 cmd1 data");
        rd(2'd0, 32'd0, "R9 cmd1 word0");
        cmd(8'd3);

        // Invalid selector
        wr(2'd0, 4'hF, 8);
        rd(2'd1, 32'd0, "R2 bad sel status");
        rd(2'd2, 32'd0, "R2 bad sel data");
        rd(2'd0, 32'd0, "R2 bad sel word0");
        wr(2'd1, 4'b0001, 32'h10);
        cmd(8'd1);
        wr(2'd0, 4'hF, 6);
        rd(2'd2, id_lo(6), "R2 cmd write dropped");
        rd(2'd1, 32'h01,   "R2 ctl write dropped");

        // Remove, firmware eject, eject
        hot(8'h00, 8'h40, 1'b1, "R4 gpe on remove");
        rd(2'd1, 32'h05, "R4 remove status");
        hot(8'h00, 8'h80, 1'b0, "R4 remove of absent cpu");
        wr(2'd1, 4'b0001, 32'hE1);
        rd(2'd1, 32'h05, "R6 reserved ctl bits");
        wr(2'd1, 4'b0001, 32'h10);
        rd(2'd1, 32'h15, "R6 firmware eject flag");
        wr(2'd1, 4'b0001, 32'h08);
        chk("R5 eject pulse", 32'(eject_pulse), 1);
        chk("R5 eject cpu", 32'(eject_cpu), 6);
        chk("R5 eject gpe", 32'(gpe_pulse), 1);
        rd(2'd1, 32'h00, "R5 eject status");

        // OST
        cmd(8'd1);
        wr(2'd2, 4'hF, 32'h103);
        chk("R10 no pulse on event", 32'(ost_pulse), 0);
        cmd(8'd2);
        wr(2'd2, 4'hF, 32'h2);
        chk("R10 ost pulse", 32'(ost_pulse), 1);
        chk("R10 ost event", ost_event, 32'h103);
        chk("R10 ost status", ost_status, 32'h2);

        // Reserved areas and partial strobes
        rd(2'd3, 32'd0, "R11 word3");
        cmd(8'd3);
        wr(2'd1, 4'b1100, 32'hFFFF_0000);
        rd(2'd2, id_lo(6), "R11 upper ctl bytes");
        wr(2'd0, 4'b0001, 32'h2);
        rd(2'd2, id_lo(6), "R11 partial selector");

        // Selector survives reset
        wr(2'd0, 4'hF, 4);
        do_reset();
        rd(2'd2, 32'd4, "R1 selector kept");
        rd(2'd1, 32'd0, "R1 cpu4 status after reset");

        @(negedge clk);
        chk("R12 all reads answered", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule